// File: doc/BRIEF.md
# Coverage-Weighted Alpha Colour Blender

This block merges two premultiplied RGBA pixels, one in front and one behind, into a single pixel. A coverage fraction that comes with the pair says how much of the pixel area belongs to the front sample. The block uses that fraction to build two asymmetric blend factors. Each colour channel is the sum of the back colour scaled by the back factor and the front colour scaled by the front factor. The composite alpha is the usual "over" union of the two alphas. A 16-bit depth word travels alongside the pair and is copied unchanged into the result.

The arithmetic runs on two shared 9x9-bit multipliers. The pair is scheduled over five compute phases inside a six-clock slot, so one pixel pair can enter every six clocks. The result leaves as a stream of six bytes on one 8-bit bus. A one-cycle strobe marks the first byte. Internally, alpha is 9 bits wide, which lets an external 0xFF stand for exactly 1.0.

Top module: `blend_core`

## Requirements
- R1: A pair is captured on the rising edge where `in_valid` is high. `out_valid` is high for exactly one cycle, seen at the sixth rising edge after the capturing edge. Pairs may be presented every 6 cycles or more slowly.
- R2: Starting in the `out_valid` cycle, `out_data` carries six consecutive bytes in this order: depth low byte, depth high byte, alpha, R, G, B. The depth bytes equal `in_z`. After the sixth byte, `out_data` is zero until the next stream.
- R3: On entry, each 8-bit alpha `a` becomes the 9-bit value `a + a[7]`. This maps 0xFF to 256, which is 1.0.
- R4: The composite 9-bit alpha is `A = aB + aF - floor(aB*aF/256)`. The output alpha byte is `A - 1` when `A > 128`, otherwise `A`, truncated to 8 bits.
- R5: Coverage `in_beta` is 5 bits, with 16 meaning 1.0. Any value above 16 acts exactly as 16.
- R6: The back factor is `256 - floor(aF*b/16)` and the front factor is `256 - floor(aB*(16-b)/16)`. Here `b` is the clamped coverage and the alphas are the 9-bit remapped values.
- R7: Each colour channel is `floor(cB*facB/256) + floor(cF*facF/256)`, saturated at 255. In the packed colour inputs, R is bits [23:16], G is bits [15:8] and B is bits [7:0].
- R8: If the front pixel is transparent black (alpha and all colours zero), the output alpha and colours equal the back pixel. The same holds with the roles of the two pixels exchanged.
- R9: While reset is asserted, `out_valid` is low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Capture strobe for one pixel pair |
| in_z | input | 16 | Depth word copied to the output |
| in_beta | input | 5 | Front coverage fraction, 16 = 1.0 |
| in_front_a | input | 8 | Front alpha |
| in_front_rgb | input | 24 | Front colour {R,G,B}, premultiplied |
| in_back_a | input | 8 | Back alpha |
| in_back_rgb | input | 24 | Back colour {R,G,B}, premultiplied |
| out_valid | output | 1 | High with the first byte of a result stream |
| out_data | output | 8 | Result byte stream |

## Verification
The assertions assume that `in_valid` pulses are at least six cycles apart. They also assume that no pulse arrives in the first two cycles after reset release, while the internal reset synchronizer is still clearing; an input check in the checker enforces both rules. The stimulus waits four cycles after reset release. It then spaces pairs by random gaps of six to eight cycles, and some pairs run at the minimum gap, so one stream follows straight after the previous one. Random operands cover every coverage code, including the values above 16. Directed pairs hit the transparent, fully opaque, saturating and alpha-midpoint cases.

// File: rtl/blend_pkg.sv
package blend_pkg;
  // Compute phases inside one pixel slot
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FAC   = 3'd1,
    PH_R     = 3'd2,
    PH_G     = 3'd3,
    PH_B     = 3'd4,
    PH_ALPHA = 3'd5
  } blend_phase_e;
endpackage

// File: rtl/blend_alpha_in.sv
module blend_alpha_in #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] a,
  output logic [CW:0]   a_ext
);
  // upper half of the range is nudged up so full scale lands on 1.0
  assign a_ext = {1'b0, a} + {{CW{1'b0}}, a[CW-1]};
endmodule

// File: rtl/blend_mul.sv
module blend_mul #(
  parameter int W = 9
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  assign p = x * y;
endmodule

// File: rtl/blend_ser.sv
module blend_ser #(
  parameter int CW = 8,
  parameter int NB = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NB*CW-1:0] load_data,
  output logic            first,
  output logic [CW-1:0]   data
);
  localparam int SW = NB * CW;

  logic [SW-1:0] sh_q, sh_d;
  logic          first_q;

  always_comb begin
    if (load) sh_d = load_data;
    else      sh_d = sh_q >> CW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      first_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      first_q <= load;
    end
  end

  assign first = first_q;
  assign data  = sh_q[CW-1:0];
endmodule

// File: rtl/blend_core.sv
module blend_core
  import blend_pkg::*;
#(
  parameter int CW = 8,
  parameter int BW = 5,
  parameter int ZW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ZW-1:0]   in_z,
  input  logic [BW-1:0]   in_beta,
  input  logic [CW-1:0]   in_front_a,
  input  logic [3*CW-1:0] in_front_rgb,
  input  logic [CW-1:0]   in_back_a,
  input  logic [3*CW-1:0] in_back_rgb,
  output logic            out_valid,
  output logic [CW-1:0]   out_data
);
  localparam int AW      = CW + 1;
  localparam int PW      = 2 * AW;
  localparam int NB      = ZW / CW + 4;
  localparam int SH_COV  = BW - 1;
  localparam logic [AW-1:0] A_ONE  = AW'(1) << CW;
  localparam logic [AW:0]   A_HALF = (AW+1)'(1) << (CW - 1);
  localparam logic [BW-1:0] B_ONE  = BW'(1) << SH_COV;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // entry alpha remap
  logic [AW-1:0] af_ext, ab_ext;
  blend_alpha_in #(.CW(CW)) u_af (.a(in_front_a), .a_ext(af_ext));
  blend_alpha_in #(.CW(CW)) u_ab (.a(in_back_a),  .a_ext(ab_ext));

  // operand capture
  logic [ZW-1:0]   z_q;
  logic [BW-1:0]   cov_d, cov_q, ncov_d, ncov_q;
  logic [AW-1:0]   af_q, ab_q;
  logic [3*CW-1:0] frgb_q, brgb_q;

  always_comb begin
    cov_d  = (in_beta > B_ONE) ? B_ONE : in_beta;
    ncov_d = B_ONE - cov_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      z_q    <= '0;
      cov_q  <= '0;
      ncov_q <= '0;
      af_q   <= '0;
      ab_q   <= '0;
      frgb_q <= '0;
      brgb_q <= '0;
    end else if (in_valid) begin
      z_q    <= in_z;
      cov_q  <= cov_d;
      ncov_q <= ncov_d;
      af_q   <= af_ext;
      ab_q   <= ab_ext;
      frgb_q <= in_front_rgb;
      brgb_q <= in_back_rgb;
    end
  end

  // phase sequencer
  blend_phase_e ph_q, ph_d;
  always_comb begin
    ph_d = ph_q;
    if (in_valid) ph_d = PH_FAC;
    else begin
      case (ph_q)
        PH_FAC:   ph_d = PH_R;
        PH_R:     ph_d = PH_G;
        PH_G:     ph_d = PH_B;
        PH_B:     ph_d = PH_ALPHA;
        default:  ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ph_q <= PH_IDLE;
    else             ph_q <= ph_d;
  end

  // operand steering: slot 0 serves the front side, slot 1 the back side
  logic [AW-1:0] fac_f_q, fac_b_q;
  logic [CW-1:0] cf_sel, cb_sel;
  logic [AW-1:0] op_x [2];
  logic [AW-1:0] op_y [2];
  logic [PW-1:0] prod [2];

  always_comb begin
    case (ph_q)
      PH_R:    begin cf_sel = frgb_q[3*CW-1:2*CW]; cb_sel = brgb_q[3*CW-1:2*CW]; end
      PH_G:    begin cf_sel = frgb_q[2*CW-1:CW];   cb_sel = brgb_q[2*CW-1:CW];   end
      PH_B:    begin cf_sel = frgb_q[CW-1:0];      cb_sel = brgb_q[CW-1:0];      end
      default: begin cf_sel = '0;                  cb_sel = '0;                  end
    endcase
  end

  always_comb begin
    op_x[0] = '0; op_y[0] = '0;
    op_x[1] = '0; op_y[1] = '0;
    case (ph_q)
      PH_FAC: begin
        op_x[0] = ab_q; op_y[0] = AW'(ncov_q);
        op_x[1] = af_q; op_y[1] = AW'(cov_q);
      end
      PH_R, PH_G, PH_B: begin
        op_x[0] = fac_f_q; op_y[0] = {1'b0, cf_sel};
        op_x[1] = fac_b_q; op_y[1] = {1'b0, cb_sel};
      end
      PH_ALPHA: begin
        op_x[0] = ab_q; op_y[0] = af_q;
      end
      default: ;
    endcase
  end

  for (genvar s = 0; s < 2; s++) begin : g_mul
    blend_mul #(.W(AW)) u_mul (.x(op_x[s]), .y(op_y[s]), .p(prod[s]));
  end

  // factor stage
  logic [AW-1:0] fac_f_d, fac_b_d;
  always_comb begin
    fac_f_d = A_ONE - AW'(prod[0] >> SH_COV);
    fac_b_d = A_ONE - AW'(prod[1] >> SH_COV);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      fac_f_q <= '0;
      fac_b_q <= '0;
    end else if (ph_q == PH_FAC) begin
      fac_f_q <= fac_f_d;
      fac_b_q <= fac_b_d;
    end
  end

  // colour stage with saturation
  logic [CW:0]     csum;
  logic [CW-1:0]   cres;
  logic [3*CW-1:0] rgb_q, rgb_d;
  always_comb begin
    csum  = (CW+1)'(prod[0] >> CW) + (CW+1)'(prod[1] >> CW);
    cres  = csum[CW] ? {CW{1'b1}} : csum[CW-1:0];
    rgb_d = rgb_q;
    case (ph_q)
      PH_R:    rgb_d[3*CW-1:2*CW] = cres;
      PH_G:    rgb_d[2*CW-1:CW]   = cres;
      PH_B:    rgb_d[CW-1:0]      = cres;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) rgb_q <= '0;
    else             rgb_q <= rgb_d;
  end

  // alpha union and exit remap
  logic [AW:0]   asum, aexit;
  logic [CW-1:0] a_out;
  always_comb begin
    asum  = {1'b0, af_q} + {1'b0, ab_q} - (AW+1)'(prod[0] >> CW);
    aexit = (asum > A_HALF) ? asum - 1'b1 : asum;
    a_out = aexit[CW-1:0];
  end

  // byte stream, depth low byte first
  logic            ser_load;
  logic [NB*CW-1:0] ser_data;
  assign ser_load = (ph_q == PH_ALPHA);
  assign ser_data = {rgb_q[CW-1:0], rgb_q[2*CW-1:CW], rgb_q[3*CW-1:2*CW], a_out, z_q};

  blend_ser #(.CW(CW), .NB(NB)) u_ser (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load      (ser_load),
    .load_data (ser_data),
    .first     (out_valid),
    .data      (out_data)
  );
endmodule

// File: rtl/blend_chk.sv
module blend_chk #(
  parameter int CW = 8,
  parameter int ZW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [ZW-1:0] in_z,
  input logic          out_valid,
  input logic [CW-1:0] out_data
);
  logic [3:0] cyc_q;
  logic [2:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      gap_q <= '0;
    end else begin
      if (cyc_q != 4'd15) cyc_q <= cyc_q + 4'd1;
      if (in_valid)            gap_q <= 3'd5;
      else if (gap_q != 3'd0)  gap_q <= gap_q - 3'd1;
    end
  end

  // R1 input rule: six-cycle spacing, nothing while the synchronizer clears
  in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (gap_q == 3'd0 && cyc_q >= 4'd2));

  // R1
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'd6) |-> (out_valid == $past(in_valid, 6)));

  // R9
  early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q < 4'd6) |-> (!out_valid && out_data == '0));

  // R2
  zlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'd6 && out_valid) |-> (out_data == $past(in_z[CW-1:0], 6)));

  // R2
  zhi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'd7 && $past(out_valid)) |-> (out_data == $past(in_z[2*CW-1:CW], 7)));
endmodule

bind blend_core blend_chk #(.CW(CW), .ZW(ZW)) u_blend_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_z      (in_z),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_blend_core.sv
`timescale 1ns/1ps
module tb_blend_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_z;
  logic [4:0]  in_beta;
  logic [7:0]  in_front_a, in_back_a;
  logic [23:0] in_front_rgb, in_back_rgb;
  logic        out_valid;
  logic [7:0]  out_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit mon_en = 1'b0;

  int          q_cyc[$];
  logic [47:0] q_exp[$];
  string       q_tag[$];

  logic [47:0] cur_exp;
  string       cur_tag;
  int          pos = 7;

  blend_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_z(in_z), .in_beta(in_beta),
    .in_front_a(in_front_a), .in_front_rgb(in_front_rgb),
    .in_back_a(in_back_a), .in_back_rgb(in_back_rgb),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [47:0] model(input logic [15:0] z, input logic [4:0] beta,
                                        input logic [7:0] fa, input logic [23:0] frgb,
                                        input logic [7:0] ba, input logic [23:0] brgb);
    int b, fe, be, fac_b, fac_f, ac, c;
    logic [47:0] r;
    b  = (beta > 16) ? 16 : int'(beta);
    fe = int'(fa) + (fa >= 8'd128 ? 1 : 0);
    be = int'(ba) + (ba >= 8'd128 ? 1 : 0);
    fac_b = 256 - (fe * b) / 16;
    fac_f = 256 - (be * (16 - b)) / 16;
    ac = be + fe - (be * fe) / 256;
    if (ac > 128) ac = ac - 1;
    r[15:0]  = z;
    r[23:16] = ac[7:0];
    for (int ch = 0; ch < 3; ch++) begin
      c = (int'(brgb[(2-ch)*8 +: 8]) * fac_b) / 256 + (int'(frgb[(2-ch)*8 +: 8]) * fac_f) / 256;
      if (c > 255) c = 255;
      r[24 + ch*8 +: 8] = c[7:0];
    end
    return r;
  endfunction

  function automatic string byte_req(input int i);
    if (i < 2)       return "R2 depth";
    else if (i == 2) return "R3/R4 alpha";
    else             return "R6/R7 colour";
  endfunction

  task automatic send(input logic [15:0] z, input logic [4:0] beta,
                      input logic [7:0] fa, input logic [23:0] frgb,
                      input logic [7:0] ba, input logic [23:0] brgb,
                      input logic [47:0] exp_v, input string tag, input int gap);
    @(negedge clk);
    in_z = z; in_beta = beta;
    in_front_a = fa; in_front_rgb = frgb;
    in_back_a = ba;  in_back_rgb = brgb;
    in_valid = 1'b1;
    q_cyc.push_back(cyc);
    q_exp.push_back(exp_v);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_m(input logic [15:0] z, input logic [4:0] beta,
                        input logic [7:0] fa, input logic [23:0] frgb,
                        input logic [7:0] ba, input logic [23:0] brgb,
                        input string tag, input int gap);
    send(z, beta, fa, frgb, ba, brgb, model(z, beta, fa, frgb, ba, brgb), tag, gap);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        n_chk++;
        if (q_cyc.size() == 0) begin
          n_fail++;
          $display("FAIL R1 unexpected out_valid: got 1 exp 0 at cycle %0d", cyc);
          pos = 7;
        end else begin
          if (cyc - q_cyc[0] != 6) begin
            n_fail++;
            $display("FAIL R1 latency: got %0d exp 6", cyc - q_cyc[0]);
          end
          cur_exp = q_exp.pop_front();
          cur_tag = q_tag.pop_front();
          void'(q_cyc.pop_front());
          pos = 0;
        end
      end
      if (pos < 6) begin
        n_chk++;
        if (out_data !== cur_exp[pos*8 +: 8]) begin
          n_fail++;
          $display("FAIL %s %s byte %0d: got %h exp %h", byte_req(pos), cur_tag, pos,
                   out_data, cur_exp[pos*8 +: 8]);
        end
        pos++;
      end else if (pos == 6) begin
        n_chk++;
        if (out_data !== 8'h00) begin
          n_fail++;
          $display("FAIL R2 idle byte: got %h exp 00", out_data);
        end
        pos = 7;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired: got hang exp completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] z;
    logic [23:0] fr, br;
    logic [7:0]  fa, ba;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; in_z = '0; in_beta = '0;
    in_front_a = '0; in_front_rgb = '0; in_back_a = '0; in_back_rgb = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    n_chk++;
    if (out_valid !== 1'b0 || out_data !== 8'h00) begin
      n_fail++;
      $display("FAIL R9 reset outputs: got %b/%h exp 0/00", out_valid, out_data);
    end
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // R8 transparent front: result is the back pixel
    send(16'hBEEF, 5'd9, 8'h00, 24'h000000, 8'hC3, 24'h804020,
         {8'h20, 8'h40, 8'h80, 8'hC3, 16'hBEEF}, "R8 transparent front", 6);
    // R8 transparent back: result is the front pixel
    send(16'h1234, 5'd3, 8'h7F, 24'h7F1005, 8'h00, 24'h000000,
         {8'h05, 8'h10, 8'h7F, 8'h7F, 16'h1234}, "R8 transparent back", 6);
    // opaque pair, full coverage: front wins
    send(16'h0001, 5'd16, 8'hFF, 24'hFF0000, 8'hFF, 24'h00FF00,
         {8'h00, 8'h00, 8'hFF, 8'hFF, 16'h0001}, "R6 full coverage", 6);
    // opaque pair, zero coverage: back wins
    send(16'hFFFE, 5'd0, 8'hFF, 24'hFF0000, 8'hFF, 24'h00FF00,
         {8'h00, 8'hFF, 8'h00, 8'hFF, 16'hFFFE}, "R6 zero coverage", 6);
    // R5 coverage above 16 behaves as 16
    send(16'h5A5A, 5'd31, 8'h90, 24'h903010, 8'hA0, 24'h20A050,
         model(16'h5A5A, 5'd16, 8'h90, 24'h903010, 8'hA0, 24'h20A050), "R5 coverage clamp", 6);
    send(16'hA5A5, 5'd17, 8'h40, 24'h402000, 8'hFF, 24'hFFFFFF,
         model(16'hA5A5, 5'd16, 8'h40, 24'h402000, 8'hFF, 24'hFFFFFF), "R5 coverage clamp", 6);
    // R7 saturation: light alphas, full colours
    send(16'h0F0F, 5'd8, 8'h10, 24'hFFFFFF, 8'h10, 24'hFFFFFF,
         {8'hFF, 8'hFF, 8'hFF, 8'h1F, 16'h0F0F}, "R7 saturation", 6);
    // R3/R4 alpha midpoint round trip
    send(16'h0080, 5'd5, 8'h80, 24'h000000, 8'h00, 24'h000000,
         {8'h00, 8'h00, 8'h00, 8'h80, 16'h0080}, "R3 midpoint", 6);
    send_m(16'h7777, 5'd12, 8'h81, 24'h112233, 8'hFE, 24'h445566, "R4 mixed", 7);

    for (int i = 0; i < 60; i++) begin
      z  = 16'($urandom);
      fa = 8'($urandom); ba = 8'($urandom);
      fr = 24'($urandom); br = 24'($urandom);
      send_m(z, 5'($urandom % 32), fa, fr, ba, br, "random", 6 + int'($urandom % 3));
    end

    repeat (12) @(negedge clk);
    n_chk++;
    if (q_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL R1 missing results: got %0d pending exp 0", q_cyc.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule